// File: doc/BRIEF.md
# On-Off-Keyed Isolation Transmit Modulator

This block turns one data bit into an on-off-keyed carrier on a complementary output pair. The pair drives the primary winding of a pulse transformer across an isolation barrier. The carrier is generated inside the block by a phase-accumulator oscillator that runs on the fast system clock. A 3-bit trim code picks one of seven nominal carrier frequencies, so the carrier can be moved away from frequency bands that are sensitive at system level.

A polarity input selects which data level sends carrier. The receiver has a matching polarity control, so the end-to-end data sense does not change. An active-high enable holds both outputs low, for example while the system powers up.

The control inputs are asynchronous to the system clock and pass through a synchronizer. Gating of the carrier changes only when the carrier changes phase, so every pulse on the pair lasts a whole half period. Trim code 7 is not a legal setting. The block treats it as a disable and keeps an error flag set until the next reset.

Top module: `ook_tx_mod`

## Requirements
- R1: The carrier phase step for trim code c is round(F(c) * 2^ACC_W / SYS_KHZ), where ACC_W is the accumulator width, SYS_KHZ is the system clock frequency in kHz, and F(c) in kHz is 15300, 13800, 11300, 10200, 8210, 6860 and 5910 for c = 0 to 6. While sending, txp rises floor(N * step / 2^ACC_W) times in N cycles, with a tolerance of one.
- R2: While sending with a steady trim code, the high and low half periods of the carrier differ by at most one system clock cycle.
- R3: While tx_en is low, both txp and txn are 0, whatever the values of data, polarity or trim. The outputs settle within two synchronizer cycles plus one half period.
- R4: With pol_inv = 0, tx_data = 1 sends carrier and tx_data = 0 holds both outputs at 0.
- R5: With pol_inv = 1 the mapping is reversed: tx_data = 0 sends carrier and tx_data = 1 holds both outputs at 0.
- R6: txp and txn are never 1 in the same cycle. While sending, exactly one of them is 1 in every cycle: txp = 1 in the carrier high phase and txn = 1 in the low phase.
- R7: Trim code 7 (binary 111) forces both outputs to 0. In the same cycle trim_err goes to 1, three clock edges after the code is applied. trim_err stays 1 after the trim code becomes legal again, until reset.
- R8: Every run of txp = 1 or txn = 1 lasts floor(2^(ACC_W-1)/step) or one cycle more, including the first and last pulse of a burst, however data and enable toggle.
- R9: During reset, txp, txn and trim_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that drives the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_en | input | 1 | Active-high enable; low holds both outputs at 0 |
| tx_data | input | 1 | Data bit to transmit |
| pol_inv | input | 1 | 0: data 1 sends carrier; 1: data 0 sends carrier |
| trim | input | 3 | Carrier frequency select; code 7 is illegal |
| txp | output | 1 | Positive side of the complementary carrier pair |
| txn | output | 1 | Negative side of the complementary carrier pair |
| trim_err | output | 1 | Set when trim code 7 is seen; stays set until reset |

## Verification
The bench toggles data and enable at offsets that do not line up with the carrier, then measures every pulse length on the pair. A gate that followed the inputs directly would produce short pulses at the start or end of a burst. Each legal trim code is checked by counting edges and comparing half-period lengths. A wrong step table shifts the frequency, and a carrier taken from anything other than the accumulator MSB unbalances the duty cycle. The bench also selects the illegal code while sending and then restores a legal code. A design that did not hold the error flag, or that kept sending on the illegal code, fails these checks.

// File: rtl/ook_tx_pkg.sv
package ook_tx_pkg;

  localparam int TRIM_W = 3;
  localparam int NUM_CODES = 1 << TRIM_W;
  localparam logic [TRIM_W-1:0] TRIM_ILLEGAL = 3'b111;

  // Control bundle carried through the synchronizer
  typedef struct packed {
    logic             en;
    logic             data;
    logic             pol;
    logic [TRIM_W-1:0] trim;
  } ctl_t;

  // Nominal carrier frequency in kHz for each trim code
  function automatic int unsigned carrier_khz(input logic [TRIM_W-1:0] code);
    case (code)
      3'd0:    return 15300;
      3'd1:    return 13800;
      3'd2:    return 11300;
      3'd3:    return 10200;
      3'd4:    return 8210;
      3'd5:    return 6860;
      3'd6:    return 5910;
      default: return 0;
    endcase
  endfunction

  // Rounded phase increment for an accumulator of acc_w bits
  function automatic longint unsigned phase_step(input logic [TRIM_W-1:0] code,
                                                 input int acc_w,
                                                 input int sys_khz);
    longint unsigned num;
    num = (longint'(carrier_khz(code)) << acc_w) + longint'(sys_khz / 2);
    return num / longint'(sys_khz);
  endfunction

endpackage

// File: rtl/ook_rst_sync.sv
module ook_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ook_sync_bus.sv
module ook_sync_bus #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ook_nco.sv
module ook_nco
  import ook_tx_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int SYS_KHZ = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIM_W-1:0] trim_s,
  output logic              carrier_nxt,
  output logic              toggle_nxt,
  output logic              illegal
);

  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] step_tbl [NUM_CODES];
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_ld;

  // Step table computed per code at elaboration
  for (genvar c = 0; c < NUM_CODES; c++) begin : g_step
    localparam longint unsigned STEP = phase_step(TRIM_W'(c), ACC_W, SYS_KHZ);
    assign step_tbl[c] = ACC_W'(STEP);
  end

  assign illegal = (trim_s == TRIM_ILLEGAL);
  assign acc_ld  = 1'b1;

  always_comb begin
    if (illegal) begin
      acc_d = '0;
    end else begin
      acc_d = acc_q + step_tbl[trim_s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_ld) begin
      acc_q <= acc_d;
    end
  end

  assign carrier_nxt = acc_d[MSB];
  assign toggle_nxt  = acc_d[MSB] ^ acc_q[MSB];

endmodule

// File: rtl/ook_gate_out.sv
module ook_gate_out (
  input  logic clk,
  input  logic rst_n,
  input  logic want_tx,
  input  logic illegal,
  input  logic carrier_nxt,
  input  logic toggle_nxt,
  output logic txp,
  output logic txn,
  output logic trim_err
);

  logic gate_q, gate_d, gate_ld;
  logic p_q, p_d, n_q, n_d;
  logic err_q, err_d;

  // Gate may only change at a carrier phase change, except the illegal-code cutoff
  always_comb begin
    gate_ld = illegal | toggle_nxt;
    if (illegal) begin
      gate_d = 1'b0;
    end else if (toggle_nxt) begin
      gate_d = want_tx;
    end else begin
      gate_d = gate_q;
    end
    p_d   = gate_d & carrier_nxt;
    n_d   = gate_d & ~carrier_nxt;
    err_d = err_q | illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (gate_ld) begin
      gate_q <= gate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q   <= 1'b0;
      n_q   <= 1'b0;
      err_q <= 1'b0;
    end else begin
      p_q   <= p_d;
      n_q   <= n_d;
      err_q <= err_d;
    end
  end

  assign txp      = p_q;
  assign txn      = n_q;
  assign trim_err = err_q;

endmodule

// File: rtl/ook_tx_mod.sv
module ook_tx_mod
  import ook_tx_pkg::*;
#(
  parameter int ACC_W       = 24,
  parameter int SYS_KHZ     = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_data,
  input  logic              pol_inv,
  input  logic [TRIM_W-1:0] trim,
  output logic              txp,
  output logic              txn,
  output logic              trim_err
);

  localparam int CTL_W = $bits(ctl_t);

  logic rst_n_int;
  ctl_t ctl_raw, ctl_s;
  logic carrier_nxt, toggle_nxt, illegal, want_tx;

  ook_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  assign ctl_raw = '{en: tx_en, data: tx_data, pol: pol_inv, trim: trim};

  ook_sync_bus #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (ctl_raw),
    .dout  (ctl_s)
  );

  ook_nco #(.ACC_W(ACC_W), .SYS_KHZ(SYS_KHZ)) u_nco (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .trim_s      (ctl_s.trim),
    .carrier_nxt (carrier_nxt),
    .toggle_nxt  (toggle_nxt),
    .illegal     (illegal)
  );

  assign want_tx = ctl_s.en & (ctl_s.data ^ ctl_s.pol);

  ook_gate_out u_out (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .want_tx     (want_tx),
    .illegal     (illegal),
    .carrier_nxt (carrier_nxt),
    .toggle_nxt  (toggle_nxt),
    .txp         (txp),
    .txn         (txn),
    .trim_err    (trim_err)
  );

endmodule

// File: rtl/ook_tx_mod_chk.sv
module ook_tx_mod_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       tx_data,
  input logic       pol_inv,
  input logic [2:0] trim,
  input logic       txp,
  input logic       txn,
  input logic       trim_err
);

  logic        p_prev, n_prev;
  logic [15:0] run_q, last_hi, since_chg;
  logic        have_hi;
  logic [2:0]  trim_prev;
  logic        p_to_n, n_to_p;

  assign p_to_n = txn && !n_prev && p_prev;
  assign n_to_p = txp && !p_prev && n_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_prev    <= 1'b0;
      n_prev    <= 1'b0;
      run_q     <= 16'd0;
      last_hi   <= 16'd0;
      have_hi   <= 1'b0;
      trim_prev <= 3'd0;
      since_chg <= 16'd0;
    end else begin
      p_prev    <= txp;
      n_prev    <= txn;
      trim_prev <= trim;
      if (trim != trim_prev) since_chg <= 16'd0;
      else if (since_chg != 16'hFFFF) since_chg <= since_chg + 16'd1;
      if (txp != p_prev || txn != n_prev) run_q <= 16'd1;
      else if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
      if (p_to_n) begin
        last_hi <= run_q;
        have_hi <= 1'b1;
      end else if (!txp && !txn) begin
        have_hi <= 1'b0;
      end
    end
  end

  // R6: never both sides driven high
  p_never_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(txp && txn));

  // R3, R4, R5: idle request two samples back means no new pulse may start
  p_idle_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tx_en, 2) || ($past(tx_data, 2) == $past(pol_inv, 2)) || ($past(trim, 2) == 3'b111))
    |=> (!$rose(txp) && !$rose(txn)));

  // R7: error flag holds once set
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trim_err) |-> trim_err);

  // R7: outputs quiet in the cycle the error is raised
  p_forbid_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trim_err) |-> (!txp && !txn));

  // R2: low half period matches the preceding high half within one cycle
  p_half_balance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (n_to_p && have_hi && (since_chg > run_q + last_hi + 16'd4))
    |-> ((run_q <= last_hi + 16'd1) && (last_hi <= run_q + 16'd1)));

endmodule

bind ook_tx_mod ook_tx_mod_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .tx_data  (tx_data),
  .pol_inv  (pol_inv),
  .trim     (trim),
  .txp      (txp),
  .txn      (txn),
  .trim_err (trim_err)
);

// File: tb/sim_ook_tx_mod.sv
`timescale 1ns/1ps
module sim_ook_tx_mod;

  localparam int ACC_W   = 24;
  localparam int SYS_KHZ = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, dat, pol;
  logic [2:0] trim;
  logic       txp, txn, err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int obs_rise, obs_both, obs_idle, run_min, run_max;

  always #5 clk = ~clk;

  ook_tx_mod #(.ACC_W(ACC_W), .SYS_KHZ(SYS_KHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(en), .tx_data(dat), .pol_inv(pol),
    .trim(trim), .txp(txp), .txn(txn), .trim_err(err)
  );

  function automatic longint exp_step(input int code);
    longint f;
    case (code)
      0: f = 15300; 1: f = 13800; 2: f = 11300; 3: f = 10200;
      4: f = 8210;  5: f = 6860;  default: f = 5910;
    endcase
    return ((f << ACC_W) + SYS_KHZ / 2) / SYS_KHZ;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watches the pair; run lengths only for runs seen from their start
  task automatic observe(input int cycles);
    logic pp, pn;
    int   len;
    bit   valid;
    obs_rise = 0; obs_both = 0; obs_idle = 0; run_min = 1 << 30; run_max = 0;
    @(negedge clk);
    pp = txp; pn = txn; len = 1; valid = 0;
    for (int i = 1; i < cycles; i++) begin
      @(negedge clk);
      if (txp && txn) obs_both++;
      if (!txp && !txn) obs_idle++;
      if (txp && !pp) obs_rise++;
      if (txp != pp || txn != pn) begin
        if (valid && (pp || pn)) begin
          if (len < run_min) run_min = len;
          if (len > run_max) run_max = len;
        end
        valid = 1; len = 1;
      end else begin
        len++;
      end
      pp = txp; pn = txn;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; en = 0; dat = 0; pol = 0; trim = 3'd0;
    wait_cyc(4);
    check(txp == 1'b0, "R9", "txp in reset", txp, 0);
    check(txn == 1'b0, "R9", "txn in reset", txn, 0);
    check(err == 1'b0, "R9", "trim_err in reset", err, 0);
    rst_n = 1'b1;
    wait_cyc(6);
  endtask

  task automatic t_freq(input int code);
    longint step, exp_rise, hmin;
    en = 0; trim = 3'(code);
    wait_cyc(40);
    pol = 0; dat = 1; en = 1;
    wait_cyc(60);
    observe(2000);
    step     = exp_step(code);
    exp_rise = (longint'(1999) * step) >> ACC_W;
    hmin     = (longint'(1) << (ACC_W - 1)) / step;
    check((obs_rise >= exp_rise - 1) && (obs_rise <= exp_rise + 1), "R1",
          $sformatf("rising edges code %0d", code), obs_rise, exp_rise);
    check(obs_both == 0 && obs_idle == 0, "R6",
          $sformatf("complementary pair code %0d (both+idle)", code), obs_both + obs_idle, 0);
    check((run_max - run_min <= 1) && (run_min >= hmin), "R2",
          $sformatf("half period spread code %0d", code), run_max - run_min, 1);
  endtask

  task automatic t_polarity;
    en = 1; trim = 3'd3;
    pol = 0; dat = 0; wait_cyc(60); observe(300);
    check(obs_idle == 299, "R4", "pol0 data0 idle cycles", obs_idle, 299);
    pol = 1; dat = 0; wait_cyc(60); observe(300);
    check(obs_idle == 0 && obs_rise > 0, "R5", "pol1 data0 idle cycles", obs_idle, 0);
    pol = 1; dat = 1; wait_cyc(60); observe(300);
    check(obs_idle == 299, "R5", "pol1 data1 idle cycles", obs_idle, 299);
  endtask

  task automatic t_enable;
    trim = 3'd2; pol = 0; dat = 1; en = 1;
    wait_cyc(60);
    en = 0; wait_cyc(40); observe(300);
    check(obs_idle == 299, "R3", "enable low pol0 data1 idle", obs_idle, 299);
    pol = 1; dat = 0; trim = 3'd5; wait_cyc(40); observe(300);
    check(obs_idle == 299, "R3", "enable low pol1 data0 idle", obs_idle, 299);
  endtask

  task automatic t_whole_pulses;
    longint step, hmin;
    en = 0; pol = 0; dat = 0; trim = 3'd6;
    wait_cyc(40);
    en = 1;
    step = exp_step(6);
    hmin = (longint'(1) << (ACC_W - 1)) / step;
    fork
      observe(1500);
      begin
        for (int i = 0; i < 40; i++) begin
          wait_cyc(5 + (i * 7) % 23);
          if (i % 5 == 4) en = ~en; else dat = ~dat;
        end
      end
    join
    check(run_min >= hmin, "R8", "shortest pulse", run_min, hmin);
    check(run_max <= hmin + 1, "R8", "longest pulse", run_max, hmin + 1);
    check(obs_both == 0, "R6", "both high during bursts", obs_both, 0);
  endtask

  task automatic t_forbidden;
    en = 1; pol = 0; dat = 1; trim = 3'd0;
    wait_cyc(60);
    check(err == 1'b0, "R7", "flag clear on legal code", err, 0);
    trim = 3'b111;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check(txp == 1'b0 && txn == 1'b0, "R7", "pair quiet on illegal code", txp | txn, 0);
    check(err == 1'b1, "R7", "flag set on illegal code", err, 1);
    observe(100);
    check(obs_idle == 99, "R7", "idle while illegal", obs_idle, 99);
    trim = 3'd1;
    wait_cyc(60);
    observe(200);
    check(err == 1'b1, "R7", "flag sticky after legal code", err, 1);
    check(obs_idle == 0, "R7", "sending resumes after legal code", obs_idle, 0);
  endtask

  initial begin
    rst_n = 1'b0; en = 0; dat = 0; pol = 0; trim = 3'd0;
    t_reset();
    for (int c = 0; c < 7; c++) t_freq(c);
    t_polarity();
    t_enable();
    t_whole_pulses();
    t_forbidden();
    t_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule